// File: doc/BRIEF.md
# Variable-Length Instruction Stream Decoder

The block sits between an instruction fetch path and the rest of a small eight-register machine. It takes 32-bit instruction memory words through a valid/ready handshake and emits one decoded record per instruction through a second valid/ready handshake.

Each word holds four byte fields. Bits 31:24 are the type, bits 23:16 are the argument, bits 15:8 are the source and bits 7:0 are the destination. The jump, conditional-jump and load-constant types carry a second word, which is the target or the constant. For these types the decoder holds the fields of the first word until the second word arrives, and then presents a single record of length 2.

The block rejects any encoding it does not accept and reports it as a one-word illegal record. After such a record the next word is decoded as a fresh instruction. The block does not execute instructions.

Top module: `insn_stream_decoder`

## Requirements
- R1: A legal one-word instruction yields a record with `out_kind` equal to the type byte (bits 31:24), `out_src` and `out_dst` taken from bits 10:8 and 2:0, `out_op` equal to bits 19:16 for type 8 and 0 otherwise, `out_flag` 0, `out_imm` 0, `out_len` 1 and `out_illegal` 0.
- R2: Any type byte greater than 9 makes the instruction illegal.
- R3: The types 3, 4 and 9 take two input words. Their record appears only after the second word has been accepted. It carries `out_imm` equal to the second word and `out_len` 2. For type 9 `out_dst` is the destination field. For type 3 `out_flag` is the argument field.
- R4: A register field that the type uses must hold 0 to 7. Otherwise the instruction is illegal. The register fields are the source field for types 0 and 2, the destination field for type 9, and both fields for types 5 to 8.
- R5: For type 3 the argument byte must be 0, 1 or 2. Any other value makes the instruction illegal.
- R6: For type 8 the argument byte must be 0 to 9 or 12. The values 10, 11 and 13 to 255 make the instruction illegal.
- R7: Every byte field a type does not use must be zero. Otherwise the instruction is illegal.
  - Types 0 and 2 use only the source byte.
  - Types 1 and 4 use no byte field.
  - Type 3 uses only the argument byte.
  - Type 9 uses only the destination byte.
  - Types 5, 6 and 7 need a zero argument byte.
- R8: An illegal word yields a record with `out_illegal` 1 and `out_len` 1, and with every other field 0. The word after it is decoded as the first word of a new instruction.
- R9: While `out_valid` is high and `out_ready` is low, the record stays unchanged and `in_ready` is low. No input word is lost or reordered.
- R10: A synchronous active-high `rst` clears `out_valid` and discards any held first word. `in_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Decoder accepts the word this cycle |
| in_word | input | 32 | Instruction memory word |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_kind | output | 4 | Instruction type |
| out_op | output | 4 | Binary operation code |
| out_src | output | 3 | Source register index |
| out_dst | output | 3 | Destination register index |
| out_flag | output | 2 | Condition flag of a conditional jump |
| out_imm | output | 32 | Constant or jump target of a two-word instruction |
| out_len | output | 2 | Instruction length in words |
| out_illegal | output | 1 | Encoding rejected |

## Verification
The assertions assume that the consumer obeys the handshake, so a stalled record is one where `out_valid` is high and `out_ready` is low. They also assume that `rst` is held across at least one clock edge. The bench drives `in_valid` and `out_ready` from random draws only at the falling clock edge and asserts reset for whole cycles. The input stream mixes legal encodings with single-field corruptions, so that every rejection rule is reached. This includes an illegal first word placed where a trailing word would otherwise be expected.

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder #(
  parameter int WORD_W = 32,
  parameter int REG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_kind,
  output logic [3:0]        out_op,
  output logic [2:0]        out_src,
  output logic [2:0]        out_dst,
  output logic [1:0]        out_flag,
  output logic [WORD_W-1:0] out_imm,
  output logic [1:0]        out_len,
  output logic              out_illegal
);
  localparam int BYTE_W = WORD_W / 4;

  logic [BYTE_W-1:0] f_type, f_arg, f_src, f_dst;
  assign {f_type, f_arg, f_src, f_dst} = in_word;

  logic       src_ok, dst_ok, arg_z, src_z, dst_z;
  logic       legal, two_word;
  logic       pend;
  logic [3:0] p_kind;
  logic [2:0] p_dst;
  logic [1:0] p_flag;

  assign src_ok = f_src < BYTE_W'(REG_N);
  assign dst_ok = f_dst < BYTE_W'(REG_N);
  assign arg_z  = f_arg == '0;
  assign src_z  = f_src == '0;
  assign dst_z  = f_dst == '0;

  always_comb begin
    case (f_type)
      BYTE_W'(0), BYTE_W'(2):
        legal = arg_z && dst_z && src_ok;
      BYTE_W'(1), BYTE_W'(4):
        legal = arg_z && src_z && dst_z;
      BYTE_W'(3):
        legal = src_z && dst_z && (f_arg < BYTE_W'(3));
      BYTE_W'(5), BYTE_W'(6), BYTE_W'(7):
        legal = arg_z && src_ok && dst_ok;
      BYTE_W'(8):
        legal = src_ok && dst_ok &&
                ((f_arg < BYTE_W'(10)) || (f_arg == BYTE_W'(12)));
      BYTE_W'(9):
        legal = arg_z && src_z && dst_ok;
      default:
        legal = 1'b0;
    endcase
  end

  assign two_word = (f_type == BYTE_W'(3)) ||
                    (f_type == BYTE_W'(4)) ||
                    (f_type == BYTE_W'(9));
  assign in_ready = !out_valid || out_ready;

  wire fire_in = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      p_kind      <= '0;
      p_dst       <= '0;
      p_flag      <= '0;
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_op      <= '0;
      out_src     <= '0;
      out_dst     <= '0;
      out_flag    <= '0;
      out_imm     <= '0;
      out_len     <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire_in) begin
        if (pend) begin
          pend        <= 1'b0;
          out_valid   <= 1'b1;
          out_kind    <= p_kind;
          out_op      <= '0;
          out_src     <= '0;
          out_dst     <= p_dst;
          out_flag    <= p_flag;
          out_imm     <= in_word;
          out_len     <= 2'd2;
          out_illegal <= 1'b0;
        end else if (!legal) begin
          out_valid   <= 1'b1;
          out_kind    <= '0;
          out_op      <= '0;
          out_src     <= '0;
          out_dst     <= '0;
          out_flag    <= '0;
          out_imm     <= '0;
          out_len     <= 2'd1;
          out_illegal <= 1'b1;
        end else if (two_word) begin
          pend   <= 1'b1;
          p_kind <= f_type[3:0];
          p_dst  <= f_dst[2:0];
          p_flag <= f_arg[1:0];
        end else begin
          out_valid   <= 1'b1;
          out_kind    <= f_type[3:0];
          out_op      <= f_arg[3:0];
          out_src     <= f_src[2:0];
          out_dst     <= f_dst[2:0];
          out_flag    <= '0;
          out_imm     <= '0;
          out_len     <= 2'd1;
          out_illegal <= 1'b0;
        end
      end
    end
  end

  assert_hold_record_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable({out_kind, out_op, out_src,
      out_dst, out_flag, out_imm, out_len, out_illegal}));

  assert_no_intake_stall_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_illegal_short_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_len == 2'd1 && out_kind == 4'd0);

  assert_long_kinds_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 2'd2 |->
      !out_illegal && (out_kind == 4'd3 || out_kind == 4'd4 || out_kind == 4'd9));

  assert_kind_range_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_kind <= 4'd9);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);
endmodule

// File: tb/insn_stream_decoder_tb.sv
module insn_stream_decoder_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [3:0]  out_kind;
  logic [3:0]  out_op;
  logic [2:0]  out_src;
  logic [2:0]  out_dst;
  logic [1:0]  out_flag;
  logic [31:0] out_imm;
  logic [1:0]  out_len;
  logic        out_illegal;

  always #4 clk = ~clk;

  insn_stream_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_op(out_op), .out_src(out_src),
    .out_dst(out_dst), .out_flag(out_flag), .out_imm(out_imm),
    .out_len(out_len), .out_illegal(out_illegal));

  typedef struct packed {
    logic [3:0]  kind;
    logic [3:0]  op;
    logic [2:0]  src;
    logic [2:0]  dst;
    logic [1:0]  flag;
    logic [31:0] imm;
    logic [1:0]  len;
    logic        ill;
  } rec_t;

  int total = 0, fails = 0;
  logic [31:0] words[$];
  rec_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic rec_t cur_rec();
    return '{out_kind, out_op, out_src, out_dst, out_flag, out_imm, out_len, out_illegal};
  endfunction

  function automatic void ref_dec(input logic [31:0] w, output rec_t r,
                                  output bit two, output string tag);
    int t = int'(w[31:24]), a = int'(w[23:16]), s = int'(w[15:8]), d = int'(w[7:0]);
    bit uz = 1, rg = 1, ex = 1;
    string extag = "R7";
    r = '0; two = 0;
    case (t)
      0, 2: begin uz = (a == 0 && d == 0); rg = s < 8; end
      1, 4: uz = (a == 0 && s == 0 && d == 0);
      3: begin uz = (s == 0 && d == 0); ex = a < 3; extag = "R5"; end
      5, 6, 7: begin uz = a == 0; rg = s < 8 && d < 8; end
      8: begin rg = s < 8 && d < 8; ex = (a < 10 || a == 12); extag = "R6"; end
      9: begin uz = (a == 0 && s == 0); rg = d < 8; end
      default: ;
    endcase
    if (t > 9) tag = "R8/R2";
    else if (!uz) tag = "R8/R7";
    else if (!rg) tag = "R8/R4";
    else if (!ex) tag = {"R8/", extag};
    else tag = "";
    if (tag != "") begin
      r.len = 2'd1; r.ill = 1'b1;
    end else begin
      r.kind = t[3:0];
      two = (t == 3 || t == 4 || t == 9);
      if (two) begin
        r.len = 2'd2; r.dst = d[2:0]; r.flag = (t == 3) ? a[1:0] : 2'd0;
        tag = (t == 3) ? "R3/R5" : "R3";
      end else begin
        r.len = 2'd1; r.src = s[2:0]; r.dst = d[2:0];
        r.op = (t == 8) ? a[3:0] : 4'd0;
        tag = (t == 8) ? "R1/R6" : "R1";
      end
    end
  endfunction

  function automatic logic [31:0] gen_word();
    int t = $urandom % 12;
    logic [7:0] a = 0, s = 0, d = 0;
    int k;
    case (t)
      0, 2: s = 8'($urandom % 8);
      3: a = 8'($urandom % 3);
      5, 6, 7: begin s = 8'($urandom % 8); d = 8'($urandom % 8); end
      8: begin
        k = $urandom % 11; a = (k == 10) ? 8'd12 : 8'(k);
        s = 8'($urandom % 8); d = 8'($urandom % 8);
      end
      9: d = 8'($urandom % 8);
      default: ;
    endcase
    if ($urandom % 3 == 0) begin
      k = $urandom % 4;
      if (k == 0) a = 8'($urandom);
      else if (k == 1) s = 8'($urandom);
      else if (k == 2) d = 8'($urandom);
      else a = 8'(10 + $urandom % 4);
    end
    return {t[7:0], a, s, d};
  endfunction

  initial begin
    int idx = 0, cyc = 0;
    bit prev_stall = 0, two;
    rec_t prev_rec, r, got;
    string tag;
    int i;

    words = '{32'h00000400, 32'h01000000, 32'h09000007, 32'h00000040,
              32'h08020205, 32'h03010000, 32'h0000007F, 32'h0A000000,
              32'hFF000000, 32'h06000803, 32'h03030000, 32'h09000001,
              32'h00000005, 32'h080A0102, 32'h080C0102, 32'h080D0102,
              32'h080B0000, 32'h01000001, 32'h05010102, 32'h04000000,
              32'hDEADBEEF, 32'h02000100, 32'h09010002, 32'h07000706,
              32'h03020000, 32'hFFFFFFFF};
    for (int n = 0; n < 400; n++) begin
      words.push_back(gen_word());
      if ($urandom % 4 == 0) words.push_back($urandom);
    end
    i = 0;
    while (i < words.size()) begin
      ref_dec(words[i], r, two, tag);
      if (two) begin
        if (i + 1 >= words.size()) words.push_back(32'h01000000);
        r.imm = words[i + 1];
        i += 2;
      end else i += 1;
      exp_q.push_back(r);
      tag_q.push_back(tag);
    end

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R10", "reset state valid/ready",
        {out_valid, in_ready}, 64'b01);
    rst = 0;

    while (!(idx == words.size() && exp_q.size() == 0 && !out_valid) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      got = cur_rec();
      if (prev_stall)
        chk(out_valid && got == prev_rec, "R9", "record held under stall",
            64'(got), 64'(prev_rec));
      out_ready = ($urandom % 4) != 0;
      if (idx < words.size()) begin
        in_valid = ($urandom % 4) != 0;
        in_word  = words[idx];
      end else begin
        in_valid = 0;
        in_word  = $urandom;
      end
      #1;
      if (out_valid && !out_ready)
        chk(!in_ready, "R9", "in_ready low while stalled", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R1", "unexpected record", 64'(got), 64'd0);
        else begin
          r = exp_q.pop_front();
          tag = tag_q.pop_front();
          chk(got == r, tag, "decoded record", 64'(got), 64'(r));
        end
      end
      if (in_valid && in_ready) idx++;
      prev_stall = out_valid && !out_ready;
      prev_rec   = got;
    end
    if (cyc >= 20000) chk(0, "R9", "watchdog expired", 64'(cyc), 64'd0);
    chk(exp_q.size() == 0, "R3", "all records delivered", 64'(exp_q.size()), 64'd0);

    @(negedge clk);
    out_ready = 1; in_valid = 1; in_word = 32'h09000003;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!out_valid && in_ready, "R10", "idle after mid-run reset",
        {out_valid, in_ready}, 64'b01);
    in_valid = 1; in_word = 32'h01000000;
    @(negedge clk);
    in_valid = 0;
    r = '0; r.kind = 4'd1; r.len = 2'd1;
    got = cur_rec();
    chk(out_valid && got == r, "R10", "held first word discarded by reset",
        64'(got), 64'(r));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule